// File: doc/BRIEF.md
# Segment Address Translation Unit

This block turns a logical address, given as a segment register number and a 32-bit offset, into a 32-bit linear address. Software first loads a 16-bit selector into one of six segment registers. The selector names a descriptor in either the global or the local descriptor table. The block then reads that 8-byte descriptor with two 32-bit reads on a simple memory read port. It keeps the unpacked base, limit and attribute bits in a hidden cache entry that belongs to that register.

After the load, a translation request names only the register and the offset. One cycle later the block returns the cached base plus the offset, with no memory access. It raises a fault instead when the offset exceeds the cached limit or the register was never loaded. The two table base addresses are written through a configuration port. A fetch in progress stalls only the translations that use the register being loaded; requests through every other register keep flowing.

Top module: `segxl_unit`

## Requirements
- R1: After reset every cache entry is invalid, `loadReady` is 1, `memRdEn` is 0 and `outValid` is 0.
- R2: A selector is decoded as RPL = bits [1:0], table select = bit 2, index = bits [15:3]. The descriptor address is the table base plus index × 8. The global base (written when `cfgSel`=0) is used when bit 2 is 0, and the local base (written when `cfgSel`=1) when it is 1. The RPL is returned on `outRpl` with each translation through that register.
- R3: A load issues two one-cycle `memRdEn` pulses. The first reads the low word at the descriptor address. The second reads the high word at address + 4 and is issued only after the low word's `memRdValid`. A response may arrive one or more cycles after its request.
- R4: The cached base is {high[31:24], high[7:0], low[31:16]}, the limit is {high[19:16], low[15:0]}, and the attribute `outAttr` is {high[23:20], high[15:8]}.
- R5: A request accepted while `xlatValid` and `xlatReady` are both 1 gives `outValid`=1 in the next cycle, with `outLinear` = base + offset modulo 2^32. Translation issues no memory read.
- R6: When the offset is greater than the cached limit, `outFault` is 1 and `outLinear` is 0. An offset equal to the limit is legal.
- R7: A translation through a register that was never loaded gives `outFault`=1 and `outLinear`=0.
- R8: From the cycle after a load is accepted until the cycle after its high word arrives, `xlatReady` is 0 for the register being loaded and 1 for every other register.
- R9: `loadReady` is 0 while a fetch is in progress. A `loadValid` seen in that time is ignored.
- R10: A load naming a register number of 6 or more starts no read and leaves `loadReady` at 1.
- R11: The table base is sampled when a load is accepted. Writing a table base during a fetch, or after a register is loaded, does not change that fetch's addresses or the cached translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Table base write strobe |
| cfgSel | input | 1 | 0 = global table base, 1 = local table base |
| cfgData | input | 32 | Table base value |
| loadValid | input | 1 | Load selector request |
| loadReg | input | 3 | Segment register to load |
| loadSel | input | 16 | Selector value |
| loadReady | output | 1 | Load accepted when high with loadValid |
| memRdEn | output | 1 | Memory read request pulse |
| memRdAddr | output | 32 | Memory read byte address |
| memRdValid | input | 1 | Read data valid |
| memRdData | input | 32 | Read data |
| xlatValid | input | 1 | Translation request |
| xlatReg | input | 3 | Segment register used |
| xlatOffset | input | 32 | Offset within segment |
| xlatReady | output | 1 | Translation accepted when high with xlatValid |
| outValid | output | 1 | Result valid |
| outLinear | output | 32 | Linear address (0 on fault) |
| outFault | output | 1 | Limit or unloaded-register fault |
| outRpl | output | 2 | RPL recorded at load |
| outAttr | output | 12 | Descriptor attribute bits |

## Verification
A wrong cached base, limit or attribute stays hidden until the first translation through that register. It then shows on `outLinear`, `outFault` or `outAttr` exactly one cycle after acceptance. A wrong fetch state shows within a cycle as a misplaced `memRdEn` pulse, a wrong `memRdAddr`, or a `loadReady`/`xlatReady` level that differs from the model. A mix-up in which register is pending shows as a stall on the wrong register or a commit into the wrong entry. The bench therefore translates through every register it has loaded, including while other loads are in flight.

// File: rtl/segxl_pkg.sv
package segxl_pkg;
  localparam int LIN_W   = 32;
  localparam int LIMIT_W = 20;
  localparam int ATTR_W  = 12;
  localparam int RPL_W   = 2;
  localparam int TI_BIT  = 2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_REQ_LO, ST_WAIT_LO, ST_REQ_HI, ST_WAIT_HI
  } fetchStateT;

  typedef struct packed {
    logic captureLoad;
    logic issueRead;
    logic readHi;
    logic takeLo;
    logic commitDesc;
  } ctrlStrobeT;

  typedef struct packed {
    logic               valid;
    logic [LIN_W-1:0]   base;
    logic [LIMIT_W-1:0] limit;
    logic [ATTR_W-1:0]  attr;
    logic [RPL_W-1:0]   rpl;
  } segCacheT;
endpackage

// File: rtl/segxl_ctrl.sv
module segxl_ctrl
  import segxl_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int REG_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadValid,
  input  logic [REG_W-1:0] loadReg,
  input  logic             memRdValid,
  output ctrlStrobeT       strobe,
  output logic             busy,
  output logic             loadReady
);
  fetchStateT stateQ, stateD;
  logic loadLegal;

  assign loadLegal = int'(loadReg) < NUM_SEG;
  assign busy      = (stateQ != ST_IDLE);
  assign loadReady = !busy;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      ST_IDLE: if (loadValid && loadLegal) begin
        strobe.captureLoad = 1'b1;
        stateD = ST_REQ_LO;
      end
      ST_REQ_LO: begin
        strobe.issueRead = 1'b1;
        stateD = ST_WAIT_LO;
      end
      ST_WAIT_LO: if (memRdValid) begin
        strobe.takeLo = 1'b1;
        stateD = ST_REQ_HI;
      end
      ST_REQ_HI: begin
        strobe.issueRead = 1'b1;
        strobe.readHi    = 1'b1;
        stateD = ST_WAIT_HI;
      end
      ST_WAIT_HI: if (memRdValid) begin
        strobe.commitDesc = 1'b1;
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issueRead |=> !strobe.issueRead);

  assert_lo_then_hi_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.takeLo |=> (strobe.issueRead && strobe.readHi));

  assert_load_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    (loadValid && loadReady && loadLegal) |=> !loadReady);
endmodule

// File: rtl/segxl_dp.sv
module segxl_dp
  import segxl_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 16,
  parameter int REG_W   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobeT        strobe,
  input  logic              busy,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [LIN_W-1:0]  cfgData,
  input  logic [REG_W-1:0]  loadReg,
  input  logic [SEL_W-1:0]  loadSel,
  input  logic [LIN_W-1:0]  memRdData,
  output logic [LIN_W-1:0]  memRdAddr,
  input  logic              xlatValid,
  input  logic [REG_W-1:0]  xlatReg,
  input  logic [LIN_W-1:0]  xlatOffset,
  output logic              xlatReady,
  output logic              outValid,
  output logic [LIN_W-1:0]  outLinear,
  output logic              outFault,
  output logic [RPL_W-1:0]  outRpl,
  output logic [ATTR_W-1:0] outAttr
);
  localparam int IDX_W = SEL_W - 3;

  logic [LIN_W-1:0] gdtBase, ldtBase, descAddr, loWord, tableBase, idxOffset;
  logic [REG_W-1:0] pendReg;
  logic [RPL_W-1:0] pendRpl;
  segCacheT         cacheQ [NUM_SEG];
  segCacheT         newEnt, selEnt;
  logic             xlatAccept, overLimit, faultD;

  // table bases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gdtBase <= '0;
      ldtBase <= '0;
    end else if (cfgWrEn) begin
      if (cfgSel) ldtBase <= cfgData;
      else        gdtBase <= cfgData;
    end
  end

  // selector decode and fetch address
  assign tableBase = loadSel[TI_BIT] ? ldtBase : gdtBase;
  assign idxOffset = LIN_W'({loadSel[SEL_W-1:3], 3'b000});
  assign memRdAddr = descAddr + (strobe.readHi ? LIN_W'(4) : LIN_W'(0));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      descAddr <= '0;
      pendReg  <= '0;
      pendRpl  <= '0;
      loWord   <= '0;
    end else begin
      if (strobe.captureLoad) begin
        descAddr <= tableBase + idxOffset;
        pendReg  <= loadReg;
        pendRpl  <= loadSel[RPL_W-1:0];
      end
      if (strobe.takeLo) loWord <= memRdData;
    end
  end

  // descriptor unpack
  always_comb begin
    newEnt.valid = 1'b1;
    newEnt.base  = {memRdData[31:24], memRdData[7:0], loWord[31:16]};
    newEnt.limit = {memRdData[19:16], loWord[15:0]};
    newEnt.attr  = {memRdData[23:20], memRdData[15:8]};
    newEnt.rpl   = pendRpl;
  end

  // hidden descriptor cache, one entry per segment register
  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cacheQ[g] <= '0;
      else if (strobe.commitDesc && pendReg == REG_W'(g))
        cacheQ[g] <= newEnt;
    end
  end

  // translation
  assign xlatReady  = !(busy && xlatReg == pendReg);
  assign xlatAccept = xlatValid && xlatReady;

  always_comb begin
    selEnt = '0;
    for (int i = 0; i < NUM_SEG; i++)
      if (xlatReg == REG_W'(i)) selEnt = cacheQ[i];
  end

  assign overLimit = {{(LIN_W-LIMIT_W){1'b0}}, selEnt.limit} < xlatOffset;
  assign faultD    = !selEnt.valid || overLimit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outLinear <= '0;
      outFault  <= 1'b0;
      outRpl    <= '0;
      outAttr   <= '0;
    end else begin
      outValid <= xlatAccept;
      if (xlatAccept) begin
        outFault  <= faultD;
        outLinear <= faultD ? '0 : selEnt.base + xlatOffset;
        outRpl    <= selEnt.rpl;
        outAttr   <= selEnt.attr;
      end
    end
  end

  assert_commit_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commitDesc |=> cacheQ[pendReg].valid);

  assert_accept_out_R5: assert property (@(posedge clk) disable iff (!rstN)
    xlatAccept |=> outValid);

  assert_base_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> ($stable(gdtBase) && $stable(ldtBase)));

  assert_addr_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !strobe.commitDesc) |=> $stable(descAddr));
endmodule

// File: rtl/segxl_unit.sv
module segxl_unit
  import segxl_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int SEL_W   = 16,
  localparam int REG_W  = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [LIN_W-1:0]  cfgData,
  input  logic              loadValid,
  input  logic [REG_W-1:0]  loadReg,
  input  logic [SEL_W-1:0]  loadSel,
  output logic              loadReady,
  output logic              memRdEn,
  output logic [LIN_W-1:0]  memRdAddr,
  input  logic              memRdValid,
  input  logic [LIN_W-1:0]  memRdData,
  input  logic              xlatValid,
  input  logic [REG_W-1:0]  xlatReg,
  input  logic [LIN_W-1:0]  xlatOffset,
  output logic              xlatReady,
  output logic              outValid,
  output logic [LIN_W-1:0]  outLinear,
  output logic              outFault,
  output logic [RPL_W-1:0]  outRpl,
  output logic [ATTR_W-1:0] outAttr
);
  ctrlStrobeT strobe;
  logic       busy;

  assign memRdEn = strobe.issueRead;

  segxl_ctrl #(.NUM_SEG(NUM_SEG), .REG_W(REG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadValid(loadValid), .loadReg(loadReg),
    .memRdValid(memRdValid), .strobe(strobe), .busy(busy),
    .loadReady(loadReady)
  );

  segxl_dp #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .busy(busy),
    .cfgWrEn(cfgWrEn), .cfgSel(cfgSel), .cfgData(cfgData),
    .loadReg(loadReg), .loadSel(loadSel), .memRdData(memRdData),
    .memRdAddr(memRdAddr), .xlatValid(xlatValid), .xlatReg(xlatReg),
    .xlatOffset(xlatOffset), .xlatReady(xlatReady), .outValid(outValid),
    .outLinear(outLinear), .outFault(outFault), .outRpl(outRpl),
    .outAttr(outAttr)
  );
endmodule

// File: tb/sim_segxl_unit.sv
module sim_segxl_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgSel = 1'b0;
  logic [31:0] cfgData = '0;
  logic        loadValid = 1'b0;
  logic [2:0]  loadReg = '0;
  logic [15:0] loadSel = '0;
  logic        loadReady, memRdEn;
  logic [31:0] memRdAddr;
  logic        memRdValid = 1'b0;
  logic [31:0] memRdData = '0;
  logic        xlatValid = 1'b0;
  logic [2:0]  xlatReg = '0;
  logic [31:0] xlatOffset = '0;
  logic        xlatReady, outValid, outFault;
  logic [31:0] outLinear;
  logic [1:0]  outRpl;
  logic [11:0] outAttr;

  always #10 clk = ~clk;

  segxl_unit u0 (.*);

  int nChecks = 0, nFail = 0;
  bit done = 1'b0;

  // behavioural memory
  logic [31:0] mem [0:255];
  int memLat = 0, rCnt = 0;
  logic [31:0] rData;

  // reference model state
  int          mPhase = 0, mPend = 0, mPRpl = 0;
  logic [31:0] mAddr = '0, mLo = '0, mGdt = '0, mLdt = '0;
  logic [31:0] mBase [0:5], mLim [0:5];
  logic [11:0] mAttr [0:5];
  logic [1:0]  mRpl [0:5];
  bit          mValid [0:5];
  bit          mOutValid = 1'b0, mOutFault = 1'b0;
  logic [31:0] mOutLin = '0;
  logic [1:0]  mOutRpl = '0;
  logic [11:0] mOutAttr = '0;

  always @(posedge clk) begin
    int xr;
    bit v, flt;
    logic [31:0] b, l;
    logic [11:0] a;
    logic [1:0] r;
    if (!rstN) begin
      mPhase = 0; mOutValid = 0; mGdt = 0; mLdt = 0;
      for (int i = 0; i < 6; i++) mValid[i] = 0;
    end else begin
      xr = int'(xlatReg);
      if (xlatValid && !(mPhase != 0 && xr == mPend)) begin
        v = 0; b = 0; l = 0; a = 0; r = 0;
        if (xr < 6) begin
          v = mValid[xr]; b = mBase[xr]; l = mLim[xr]; a = mAttr[xr]; r = mRpl[xr];
        end
        flt = !v || (xlatOffset > l);
        mOutValid = 1; mOutFault = flt;
        mOutLin = flt ? 32'h0 : b + xlatOffset;
        mOutRpl = r; mOutAttr = a;
      end else mOutValid = 0;
      case (mPhase)
        0: if (loadValid && int'(loadReg) < 6) begin
          mPend = int'(loadReg); mPRpl = int'(loadSel[1:0]);
          mAddr = (loadSel[2] ? mLdt : mGdt) + 32'(loadSel[15:3]) * 8;
          mPhase = 1;
        end
        1: mPhase = 2;
        2: if (memRdValid) begin mLo = memRdData; mPhase = 3; end
        3: mPhase = 4;
        4: if (memRdValid) begin
          mBase[mPend]  = {memRdData[31:24], memRdData[7:0], mLo[31:16]};
          mLim[mPend]   = {12'h0, memRdData[19:16], mLo[15:0]};
          mAttr[mPend]  = {memRdData[23:20], memRdData[15:8]};
          mRpl[mPend]   = 2'(mPRpl);
          mValid[mPend] = 1;
          mPhase = 0;
        end
        default: mPhase = 0;
      endcase
      if (cfgWrEn) begin
        if (cfgSel) mLdt = cfgData; else mGdt = cfgData;
      end
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    if (rstN) begin
      chk("R9", 32'(loadReady), 32'(mPhase == 0));
      chk("R3", 32'(memRdEn), 32'(mPhase == 1 || mPhase == 3));
      if (mPhase == 1) chk("R2", memRdAddr, mAddr);
      if (mPhase == 3) chk("R3", memRdAddr, mAddr + 4);
      chk("R8", 32'(xlatReady), 32'(!(mPhase != 0 && int'(xlatReg) == mPend)));
      chk("R5", 32'(outValid), 32'(mOutValid));
      if (mOutValid) begin
        chk("R6", 32'(outFault), 32'(mOutFault));
        chk("R5", outLinear, mOutLin);
        chk("R2", 32'(outRpl), 32'(mOutRpl));
        chk("R4", 32'(outAttr), 32'(mOutAttr));
      end
    end
    if (memRdValid) memRdValid = 1'b0;
    if (rCnt > 0) begin
      rCnt--;
      if (rCnt == 0) begin memRdValid = 1'b1; memRdData = rData; end
    end
    if (memRdEn) begin rCnt = memLat + 1; rData = mem[memRdAddr[9:2]]; end
  endtask

  task automatic putDesc(logic [31:0] addr, logic [31:0] base, logic [19:0] lim,
                         logic [7:0] acc, logic [3:0] flg);
    mem[addr[9:2]]     = {base[15:0], lim[15:0]};
    mem[addr[9:2] + 1] = {base[31:24], flg, lim[19:16], acc, base[23:16]};
  endtask

  task automatic cfgWrite(bit sel, logic [31:0] d);
    cfgWrEn = 1; cfgSel = sel; cfgData = d; tick(); cfgWrEn = 0;
  endtask

  task automatic startLoad(int rg, logic [15:0] sel);
    loadValid = 1; loadReg = 3'(rg); loadSel = sel; tick(); loadValid = 0;
  endtask

  task automatic xlat(int rg, logic [31:0] off);
    xlatValid = 1; xlatReg = 3'(rg); xlatOffset = off; tick(); xlatValid = 0; tick();
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 40 && mPhase != 0; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFail++; nChecks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    putDesc(32'h108, 32'h1234_5000, 20'h00FFF, 8'h92, 4'hC);
    putDesc(32'h218, 32'hFFFF_F000, 20'hFFFFF, 8'hF2, 4'h4);
    putDesc(32'h308, 32'h0ABC_0000, 20'h00100, 8'h93, 4'h8);
    putDesc(32'h310, 32'h0040_0000, 20'h0000F, 8'h9A, 4'h0);

    repeat (3) @(negedge clk);
    chk("R1", 32'(loadReady), 32'd1);
    chk("R1", 32'(memRdEn), 32'd0);
    chk("R1", 32'(outValid), 32'd0);
    rstN = 1'b1;
    tick();

    cfgWrite(0, 32'h100);
    cfgWrite(1, 32'h200);

    xlat(0, 32'h10);                         // never loaded
    chk("R7", 32'(outFault), 32'd1);
    chk("R7", outLinear, 32'h0);

    // R8/R9: load reg0 from global idx1, rpl3; stall reg0, reg1 flows
    startLoad(0, 16'h000B);
    xlatValid = 1; xlatReg = 3'd0; xlatOffset = 32'h4;
    tick();
    chk("R8", 32'(xlatReady), 32'd0);
    loadValid = 1; loadReg = 3'd2; loadSel = 16'h0010;   // ignored, busy
    xlatReg = 3'd1;
    tick();
    loadValid = 0; xlatValid = 0;
    tick();
    chk("R7", 32'(outFault), 32'd1);
    waitIdle();
    tick();
    xlat(2, 32'h0);
    chk("R9", 32'(outFault), 32'd1);

    xlat(0, 32'h10);
    chk("R5", outLinear, 32'h1234_5010);
    chk("R2", 32'(outRpl), 32'd3);
    chk("R4", 32'(outAttr), 32'hC92);
    xlat(0, 32'hFFF);
    chk("R6", 32'(outFault), 32'd0);
    chk("R6", outLinear, 32'h1234_5FFF);
    xlat(0, 32'h1000);
    chk("R6", 32'(outFault), 32'd1);

    // R11: local idx3, rpl1, slow memory, global base rewritten mid-fetch
    memLat = 3;
    startLoad(5, 16'h001D);
    cfgWrite(0, 32'h300);
    waitIdle();
    tick();
    xlat(5, 32'h2000);
    chk("R5", outLinear, 32'h0000_1000);
    chk("R2", 32'(outRpl), 32'd1);
    chk("R4", 32'(outAttr), 32'h4F2);
    xlat(0, 32'h20);
    chk("R11", outLinear, 32'h1234_5020);

    // R10: illegal register number
    startLoad(6, 16'h0008);
    tick();
    chk("R10", 32'(memRdEn), 32'd0);
    chk("R10", 32'(loadReady), 32'd1);

    // reload reg0 from the new global table
    memLat = 0;
    startLoad(0, 16'h0008);
    waitIdle();
    tick();
    xlat(0, 32'h100);
    chk("R11", outLinear, 32'h0ABC_0100);
    xlat(0, 32'h101);
    chk("R6", 32'(outFault), 32'd1);

    // back-to-back translations on reg0 while reg3 loads
    memLat = 1;
    startLoad(3, 16'h0010);
    xlatValid = 1; xlatReg = 3'd0;
    for (int i = 0; i < 5; i++) begin
      xlatOffset = 32'(i * 16);
      tick();
    end
    xlatValid = 0;
    waitIdle();
    tick();
    xlat(3, 32'hF);
    chk("R5", outLinear, 32'h0040_000F);
    xlat(3, 32'h10);
    chk("R6", 32'(outFault), 32'd1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule